// File: doc/BRIEF.md
# Cascaded Two-Line Delay Store

This block keeps the last two raster lines of a pixel stream so that a downstream filter can see three vertically adjacent pixels at once. Pixels are written into a first line store through a write port with its own clock. A read port on a second, unrelated clock reads that store, and on the same edge reads a second line store. Each byte read from the first store is written straight into the second store at the same address. The second output therefore trails the first by one more line.

Each port has an active-low enable and an active-low address clear. Line length is not programmed anywhere. It is the spacing between address clears. Nothing guards against overrun: the counters wrap at the store depth. The outputs carry an output-enable flag in place of tri-state pads.

Top module: `cascade_line_mem`

## Requirements
- R1: On each rising write-clock edge with `wr_en_n` low, `wr_data` is stored at the write address, and the write address then advances by one.
- R2: On a rising write-clock edge with `wr_en_n` high, nothing is stored, and the write address keeps its value regardless of `wr_data`.
- R3: With `wr_clr_n` low on a rising write-clock edge, the write address becomes zero. If `wr_en_n` is also low, that edge stores at address zero and the next address is one. A write clear leaves the read address and both outputs untouched.
- R4: On each rising read-clock edge with `rd_en_n` low, `q1_data` registers the first-store word at the read address, and the read address advances by one.
- R5: On the same enabled read edge, the first-store word going to `q1_data` is written into the second store at the read address. `q2_data` registers the second-store word that was at that address before the write, so it shows the value `q1_data` gave one line earlier.
- R6: On a rising read-clock edge with `rd_en_n` high, the read address, `q1_data` and `q2_data` all keep their values. `q_oe` is low exactly while `rd_en_n` is high.
- R7: With `rd_clr_n` low on a rising read-clock edge, the shared read address (first-store read, second-store read and write) becomes zero. If `rd_en_n` is also low, that edge uses address zero and the next address is one.
- R8: Write and read addresses wrap from DEPTH-1 to zero, and no clear erases stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Active-low write enable |
| wr_clr_n | input | 1 | Active-low write address clear, sampled on wr_clk |
| wr_data | input | WIDTH | Pixel byte entering the first store |
| rd_clk | input | 1 | Read-side clock, independent of wr_clk |
| rd_en_n | input | 1 | Active-low read enable |
| rd_clr_n | input | 1 | Active-low read address clear, sampled on rd_clk |
| q1_data | output | WIDTH | One-line-delayed pixel, registered |
| q2_data | output | WIDTH | Two-line-delayed pixel, registered |
| q_oe | output | 1 | High when the outputs are driven (read enabled) |

## Verification
Two behaviours are hard to reach from the ports. The first is address wrap combined with the cascade. Seeing both needs a line that overruns the store depth, followed by a read pass that runs past the end again. Only then are the second store's low addresses holding bytes that were wrapped into the first store. The bench uses a depth of eight: it writes a full line plus three extra pixels, reads one cleared pass, and keeps reading past the wrap point, so that both outputs show the overwritten bytes. Idle cycles on both ports, a clear with no enable, and a write clear in the middle of a read line check that the counters hold their values and that the two sides stay independent.

// File: rtl/clm_pkg.sv
// Package: shared helpers for the cascaded line store.
// Assumes depth >= 2.
package clm_pkg;

    // Address width for a given store depth (at least one bit).
    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 2) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/clm_addr_ctr.sv
// Module: clm_addr_ctr
// Wrapping address counter with an active-low clear that wins over the step.
// The address used on the current edge is zero while clear is low.
// Assumes DEPTH >= 2 and clr_n/step are synchronous to clk.
module clm_addr_ctr #(
    parameter int unsigned DEPTH = 5120,
    localparam int unsigned AW   = clm_pkg::addr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          step,
    output logic [AW-1:0] cnt,
    output logic [AW-1:0] addr_now
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] base;

    // Address in effect on this edge: zero when clearing.
    always_comb base = clr_n ? cnt : '0;

    assign addr_now = base;

    // Advance from the effective address, wrapping at the last word.
    always_ff @(posedge clk) begin
        if (!clr_n && !step) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (base == LAST) ? '0 : base + AW'(1);
        end
    end
endmodule

// File: rtl/clm_store.sv
// Module: clm_store
// One line store: clocked write port, combinational read port.
// Assumes the read address is held stable around the reader's clock edge.
// Contents are never cleared.
module clm_store #(
    parameter int unsigned DEPTH = 5120,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = clm_pkg::addr_bits(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one word on an enabled write edge.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word without a clock.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/cascade_line_mem.sv
// Module: cascade_line_mem
// Two cascaded line stores. Line store 1 is written on wr_clk. On rd_clk,
// both stores are read at one shared address, and the store-1 word is copied
// into store 2 at that address. Store 2 therefore lags by one more line.
// The three read-side counters always move together, so one counter serves
// all three. Assumes the host does not read a word while it is being written.
module cascade_line_mem #(
    parameter int unsigned DEPTH = 5120,
    parameter int unsigned WIDTH = 8
) (
    input  logic             wr_clk,
    input  logic             wr_en_n,
    input  logic             wr_clr_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             rd_en_n,
    input  logic             rd_clr_n,
    output logic [WIDTH-1:0] q1_data,
    output logic [WIDTH-1:0] q2_data,
    output logic             q_oe
);
    localparam int unsigned AW = clm_pkg::addr_bits(DEPTH);

    logic             wr_go;
    logic             rd_go;
    logic [AW-1:0]    wr_cnt;
    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    rd_cnt;
    logic [AW-1:0]    rd_addr;
    logic [WIDTH-1:0] line1_word;
    logic [WIDTH-1:0] line2_word;

    // Translate the active-low enables.
    always_comb begin
        wr_go = !wr_en_n;
        rd_go = !rd_en_n;
    end

    clm_addr_ctr #(.DEPTH(DEPTH)) u_wr_ctr (
        .clk      (wr_clk),
        .clr_n    (wr_clr_n),
        .step     (wr_go),
        .cnt      (wr_cnt),
        .addr_now (wr_addr)
    );

    clm_addr_ctr #(.DEPTH(DEPTH)) u_rd_ctr (
        .clk      (rd_clk),
        .clr_n    (rd_clr_n),
        .step     (rd_go),
        .cnt      (rd_cnt),
        .addr_now (rd_addr)
    );

    clm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_line1 (
        .wclk  (wr_clk),
        .we    (wr_go),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (line1_word)
    );

    clm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_line2 (
        .wclk  (rd_clk),
        .we    (rd_go),
        .waddr (rd_addr),
        .wdata (line1_word),
        .raddr (rd_addr),
        .rdata (line2_word)
    );

    // Register both delayed words on an enabled read edge; hold otherwise.
    always_ff @(posedge rd_clk) begin
        if (rd_go) begin
            q1_data <= line1_word;
            q2_data <= line2_word;
        end
    end

    // Outputs count as driven only while reading is enabled.
    always_comb q_oe = rd_go;
endmodule

// File: rtl/clm_checker.sv
// Module: clm_checker
// Temporal checks on the counters and outputs of cascade_line_mem.
// Each side is checked only after it has seen its first clear.
module clm_checker #(
    parameter int unsigned DEPTH = 5120,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = clm_pkg::addr_bits(DEPTH)
) (
    input logic             wr_clk,
    input logic             wr_en_n,
    input logic             wr_clr_n,
    input logic [AW-1:0]    wr_cnt,
    input logic             rd_clk,
    input logic             rd_en_n,
    input logic             rd_clr_n,
    input logic [AW-1:0]    rd_cnt,
    input logic [WIDTH-1:0] q1_data,
    input logic [WIDTH-1:0] q2_data
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic wr_seen = 1'b0;
    logic rd_seen = 1'b0;

    // Note the first write-side clear.
    always_ff @(posedge wr_clk) if (!wr_clr_n) wr_seen <= 1'b1;

    // Note the first read-side clear.
    always_ff @(posedge rd_clk) if (!rd_clr_n) rd_seen <= 1'b1;

    AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (!wr_seen)
        (!wr_en_n && wr_clr_n && wr_cnt != LAST) |=> wr_cnt == $past(wr_cnt) + AW'(1)); // R1
    AST_WR_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_seen)
        (wr_en_n && wr_clr_n) |=> $stable(wr_cnt)); // R2
    AST_WR_CLEAR: assert property (@(posedge wr_clk) disable iff (!wr_seen)
        !wr_clr_n |=> wr_cnt == ($past(wr_en_n) ? '0 : AW'(1))); // R3
    AST_RD_STEP: assert property (@(posedge rd_clk) disable iff (!rd_seen)
        (!rd_en_n && rd_clr_n && rd_cnt != LAST) |=> rd_cnt == $past(rd_cnt) + AW'(1)); // R4
    AST_RD_IDLE: assert property (@(posedge rd_clk) disable iff (!rd_seen)
        (rd_en_n && rd_clr_n) |=> ($stable(rd_cnt) && $stable(q1_data) && $stable(q2_data))); // R6
    AST_RD_CLEAR: assert property (@(posedge rd_clk) disable iff (!rd_seen)
        !rd_clr_n |=> rd_cnt == ($past(rd_en_n) ? '0 : AW'(1))); // R7
    AST_WR_WRAP: assert property (@(posedge wr_clk) disable iff (!wr_seen)
        (!wr_en_n && wr_clr_n && wr_cnt == LAST) |=> wr_cnt == '0); // R8
    AST_RD_WRAP: assert property (@(posedge rd_clk) disable iff (!rd_seen)
        (!rd_en_n && rd_clr_n && rd_cnt == LAST) |=> rd_cnt == '0); // R8
endmodule

bind cascade_line_mem clm_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_clm_checker (
    .wr_clk   (wr_clk),
    .wr_en_n  (wr_en_n),
    .wr_clr_n (wr_clr_n),
    .wr_cnt   (wr_cnt),
    .rd_clk   (rd_clk),
    .rd_en_n  (rd_en_n),
    .rd_clr_n (rd_clr_n),
    .rd_cnt   (rd_cnt),
    .q1_data  (q1_data),
    .q2_data  (q2_data)
);

// File: tb/cascade_line_mem_test.sv
// Bench for cascade_line_mem at depth 8. Expected pixels come from a formula
// of line number and position.
module cascade_line_mem_test;
    localparam int unsigned D = 8;
    localparam int unsigned W = 8;

    logic         wr_clk = 1'b0;
    logic         rd_clk = 1'b0;
    logic         wr_en_n = 1'b1;
    logic         wr_clr_n = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic         rd_en_n = 1'b1;
    logic         rd_clr_n = 1'b1;
    logic [W-1:0] q1_data;
    logic [W-1:0] q2_data;
    logic         q_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #2 rd_clk = ~rd_clk;
    end

    cascade_line_mem #(.DEPTH(D), .WIDTH(W)) uut (
        .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_clr_n(wr_clr_n), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_clr_n(rd_clr_n),
        .q1_data(q1_data), .q2_data(q2_data), .q_oe(q_oe)
    );

    function automatic logic [W-1:0] pix(input int line, input int pos);
        return W'(line * 17 + pos * 3 + 5);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cycle(input logic en_n, input logic clr_n, input logic [W-1:0] d);
        @(negedge wr_clk);
        wr_en_n = en_n; wr_clr_n = clr_n; wr_data = d;
        @(posedge wr_clk);
        #1;
        wr_en_n = 1'b1; wr_clr_n = 1'b1;
    endtask

    // Drive one read edge and leave the sample point 1 ns after it.
    task automatic rd_cycle(input logic en_n, input logic clr_n);
        @(negedge rd_clk);
        rd_en_n = en_n; rd_clr_n = clr_n;
        @(posedge rd_clk);
        #1;
    endtask

    task automatic rd_idle_end();
        @(negedge rd_clk);
        rd_en_n = 1'b1; rd_clr_n = 1'b1;
    endtask

    // Write one full line from address zero, with one idle beat carrying junk.
    task automatic write_line(input int line);
        for (int i = 0; i < int'(D); i++) begin
            if (i == 3) wr_cycle(1'b1, 1'b1, 8'hEE); // R2 junk not stored
            wr_cycle(1'b0, (i == 0) ? 1'b0 : 1'b1, pix(line, i)); // R1, R3
        end
    endtask

    // Read one line from address zero, with one idle beat in the middle.
    task automatic read_line(input int line);
        for (int i = 0; i < int'(D); i++) begin
            if (i == 4) begin
                rd_cycle(1'b1, 1'b1);
                chk("R6 q1 held", q1_data, pix(line, 3));
                chk("R6 oe low", W'(q_oe), W'(0));
            end
            rd_cycle(1'b0, (i == 0) ? 1'b0 : 1'b1); // R7 clear with enable
            chk("R4 q1", q1_data, pix(line, i));
            chk("R6 oe high", W'(q_oe), W'(1));
            if (line > 0) chk("R5 q2", q2_data, pix(line - 1, i));
        end
        rd_idle_end();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wr_cycle(1'b1, 1'b0, '0);
        rd_cycle(1'b1, 1'b0);
        chk("R6 reset oe", W'(q_oe), W'(0));
        rd_idle_end();

        for (int l = 0; l < 5; l++) begin
            write_line(l);
            read_line(l);
        end

        // R8: overrun the line by three words, then read across the wrap.
        write_line(5);
        for (int i = 0; i < 3; i++) wr_cycle(1'b0, 1'b1, pix(9, i));
        for (int i = 0; i < int'(D); i++) begin
            rd_cycle(1'b0, (i == 0) ? 1'b0 : 1'b1);
            chk("R8 q1 wrapped write", q1_data, (i < 3) ? pix(9, i) : pix(5, i));
            chk("R5 q2 after wrap", q2_data, pix(4, i));
        end
        for (int i = 0; i < 3; i++) begin
            rd_cycle(1'b0, 1'b1);
            chk("R8 q1 read wrap", q1_data, pix(9, i));
            chk("R8 q2 read wrap", q2_data, pix(9, i));
        end
        rd_idle_end();

        // R3, R7: clears without enable, then resume from address zero.
        wr_cycle(1'b1, 1'b0, 8'h55);
        wr_cycle(1'b0, 1'b1, pix(10, 0));
        wr_cycle(1'b0, 1'b1, pix(10, 1));
        rd_cycle(1'b1, 1'b0);
        chk("R7 clear without enable holds q1", q1_data, pix(9, 2));
        for (int i = 0; i < 2; i++) begin
            rd_cycle(1'b0, 1'b1);
            chk("R7 q1 from zero", q1_data, pix(10, i));
            chk("R7 q2 from zero", q2_data, pix(9, i));
        end
        rd_idle_end();

        // R3: a write clear mid-line leaves the read address alone.
        wr_cycle(1'b1, 1'b0, 8'h00);
        rd_cycle(1'b0, 1'b1);
        chk("R3 read address untouched q1", q1_data, pix(9, 2));
        chk("R3 read address untouched q2", q2_data, pix(9, 2));
        rd_idle_end();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule